// File: doc/BRIEF.md
# Serial Hit Edge Detector

This block examines one channel's burst of 10-bit sample words as a single serial bit stream. The stream starts at the most significant bit of the first word and continues through each following word. The block looks for pulses. A pulse begins with a rising transition that is followed by a run of four ones. It ends with a falling transition that is followed by a run of four zeros. For each pulse the block records where the pulse began and how long it lasted, both counted in sample bits. It records at most four pulses per burst.

A burst opens with a word flagged as first and closes with a word flagged as last. The channel enable and the burst length (in words) are captured with the first word. The block scans all ten bits of a word in the cycle that word is accepted. Each record is written into a four-slot result store as soon as the pulse ends. A pulse still open at the close of the burst is written at that point. A one-cycle completion strobe then presents a 4-bit status word that combines the enable with the hit count. The record slots can be read back by slot number.

Top module: `serial_hit_edge_det`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is low and `status_o` is 0000. All four record slots read 0000_0000_0000_0000 until a burst writes them.
- R2: Bit j of the stream (j counted from 0) is bit (9 - j mod 10) of word floor(j/10), with word 0 being the first word of the burst. A rising edge is a 0 followed by four 1s. The leading edge reported is the stream index of the first of those 1s.
- R3: While a pulse is open, a 1 followed by four 0s closes it. The width reported is the number of consecutive 1s, that is, the index of the first 0 minus the leading edge.
- R4: A run of fewer than four 1s opens no pulse. A gap of fewer than four 0s inside a pulse does not close it; the gap counts toward the width.
- R5: If bits 9..6 of the first word are all 1, a pulse is open from the start with leading edge 0x00. If only three or fewer of those bits are 1, that opening run is not a hit.
- R6: A pulse still open when the scanned window ends is recorded with width 0xFF.
- R7: At most four hits are recorded per burst, in order of occurrence. Later pulses are ignored. `status_o[2:0]` holds the number of hits, 0 to 4.
- R8: `status_o[3]` is the channel enable captured with the first word. For a disabled burst the status is 0000 and no record slot changes.
- R9: A leading edge at an index above 255 is reported as 0xFF. A width above 255 is reported as 0xFF.
- R10: Only the first `burst_words` words of a burst are scanned. Later words in the same burst have no effect on records or count.
- R11: `done_o` pulses high for one cycle, in the cycle after the clock edge that accepts the word flagged last. `status_o` is valid from then until the next completion. Slot s holds the record of hit s+1, with the leading edge in bits 15..8 and the width in bits 7..0.
- R12: Words offered while no burst is open, and not flagged first, are ignored and produce no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | A sample word is offered this cycle |
| in_data | input | 10 | Sample word, earliest sample in the MSB |
| in_first | input | 1 | Offered word opens a burst |
| in_last | input | 1 | Offered word closes the burst |
| chan_on | input | 1 | Channel enable, captured with the first word |
| burst_words | input | 7 | Number of words to scan, captured with the first word |
| rd_slot | input | 2 | Record slot to read |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 4 | Bit 3 enable, bits 2..0 hit count |
| rd_rec_o | output | 16 | Record in the selected slot: leading edge in 15..8, width in 7..0 |

## Verification
The checks assume the following about the inputs:
- Every burst begins with a word flagged first and ends with exactly one word flagged last.
- `burst_words` never exceeds the configured maximum word count.
- The enable and length are meaningful only alongside the first word.

The stimulus drives only on the falling clock edge. It keeps burst lengths between 1 and 40 words and leaves idle cycles between bursts. It also sends stray words, some flagged last, outside any burst so that the ignore rule is exercised. The completion-source property assumes that the last flag is only meaningful while a burst is open. The stimulus respects this, apart from the deliberate stray words, which the design must reject.

// File: rtl/shed_pkg.sv
package shed_pkg;
  // length of the qualifying run after a transition
  localparam int QUAL_RUN = 4;
  localparam int EDGE_W   = 8;
  localparam int REC_W    = 2 * EDGE_W;
  localparam int MAX_HITS = 4;
  localparam int SLOT_W   = $clog2(MAX_HITS);
  localparam int HCNT_W   = $clog2(MAX_HITS + 1);
  localparam logic [EDGE_W-1:0] EDGE_SAT = '1;

  typedef struct packed {
    logic                open;
    logic [QUAL_RUN-1:0] hist;
    logic [HCNT_W-1:0]   hits;
  } scan_st_t;

  function automatic logic [EDGE_W-1:0] clip_edge(input logic [31:0] v);
    logic [EDGE_W-1:0] r;
    r = (v > 32'(EDGE_SAT)) ? EDGE_SAT : v[EDGE_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/shed_bit_step.sv
module shed_bit_step
  import shed_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  scan_st_t           st_i,
  input  logic [IDX_W-1:0]   lead_i,
  input  logic               bit_i,
  input  logic [IDX_W-1:0]   idx_i,
  output scan_st_t           st_o,
  output logic [IDX_W-1:0]   lead_o,
  output logic               wr_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [REC_W-1:0]   rec_o
);
  localparam logic [QUAL_RUN-1:0] RISE_HIST = {1'b0, {(QUAL_RUN-1){1'b1}}};
  localparam logic [QUAL_RUN-1:0] FALL_HIST = {1'b1, {(QUAL_RUN-1){1'b0}}};

  logic             rise_seen;
  logic             fall_seen;
  logic             has_room;
  logic [IDX_W-1:0] edge_pos;
  logic [IDX_W-1:0] span;

  // history holds the previous QUAL_RUN bits, oldest in the MSB
  assign rise_seen = (st_i.hist == RISE_HIST) && bit_i;
  assign fall_seen = (st_i.hist == FALL_HIST) && !bit_i;
  assign has_room  = st_i.hits < HCNT_W'(MAX_HITS);
  assign edge_pos  = idx_i - IDX_W'(QUAL_RUN - 1);
  assign span      = edge_pos - lead_i;

  always_comb begin
    st_o      = st_i;
    st_o.hist = {st_i.hist[QUAL_RUN-2:0], bit_i};
    lead_o    = lead_i;
    wr_o      = 1'b0;
    slot_o    = SLOT_W'(st_i.hits - HCNT_W'(1));
    rec_o     = '0;
    if (!st_i.open) begin
      if (rise_seen && has_room) begin
        st_o.open = 1'b1;
        st_o.hits = st_i.hits + HCNT_W'(1);
        lead_o    = edge_pos;
      end
    end else if (fall_seen) begin
      st_o.open = 1'b0;
      wr_o      = 1'b1;
      rec_o     = {clip_edge(32'(lead_i)), clip_edge(32'(span))};
    end
  end
endmodule

// File: rtl/shed_word_scan.sv
module shed_word_scan
  import shed_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int IDX_W  = 10
) (
  input  scan_st_t          st_i,
  input  logic [IDX_W-1:0]  lead_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  base_i,
  output scan_st_t          st_o,
  output logic [IDX_W-1:0]  lead_o,
  output logic [MAX_HITS-1:0] we_o,
  output logic [REC_W-1:0]  wdata_o [MAX_HITS]
);
  scan_st_t          st_c   [WORD_W+1];
  logic [IDX_W-1:0]  lead_c [WORD_W+1];
  logic [WORD_W-1:0] wr_g;
  logic [SLOT_W-1:0] slot_g [WORD_W];
  logic [REC_W-1:0]  rec_g  [WORD_W];

  assign st_c[0]   = st_i;
  assign lead_c[0] = lead_i;

  // one stage per bit, MSB first
  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    shed_bit_step #(.IDX_W(IDX_W)) u_step (
      .st_i   (st_c[g]),
      .lead_i (lead_c[g]),
      .bit_i  (word_i[WORD_W-1-g]),
      .idx_i  (base_i + IDX_W'(g)),
      .st_o   (st_c[g+1]),
      .lead_o (lead_c[g+1]),
      .wr_o   (wr_g[g]),
      .slot_o (slot_g[g]),
      .rec_o  (rec_g[g])
    );
  end

  assign st_o   = st_c[WORD_W];
  assign lead_o = lead_c[WORD_W];

  // each slot closes at most once per word, so an OR-merge is exact
  always_comb begin
    we_o = '0;
    for (int s = 0; s < MAX_HITS; s++) wdata_o[s] = '0;
    for (int g = 0; g < WORD_W; g++) begin
      if (wr_g[g]) begin
        we_o[slot_g[g]]    = 1'b1;
        wdata_o[slot_g[g]] = rec_g[g];
      end
    end
  end
endmodule

// File: rtl/shed_result_mem.sv
module shed_result_mem
  import shed_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_HITS-1:0] we_i,
  input  logic [REC_W-1:0]    wdata_i [MAX_HITS],
  input  logic [SLOT_W-1:0]   rd_slot_i,
  output logic [REC_W-1:0]    rd_data_o
);
  logic [REC_W-1:0] cell_rd [MAX_HITS];

  for (genvar g = 0; g < MAX_HITS; g++) begin : g_cell
    logic [REC_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cell_q <= '0;
      else if (we_i[g])  cell_q <= wdata_i[g];
    end
    assign cell_rd[g] = cell_q;
  end

  assign rd_data_o = cell_rd[rd_slot_i];
endmodule

// File: rtl/serial_hit_edge_det.sv
module serial_hit_edge_det
  import shed_pkg::*;
#(
  parameter  int WORD_W    = 10,
  parameter  int MAX_WORDS = 64,
  localparam int LEN_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  input  logic              chan_on,
  input  logic [LEN_W-1:0]  burst_words,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              done_o,
  output logic [HCNT_W:0]   status_o,
  output logic [REC_W-1:0]  rd_rec_o
);
  localparam int RAW_IDX_W = $clog2(MAX_WORDS * WORD_W);
  localparam int IDX_W     = (RAW_IDX_W > EDGE_W) ? RAW_IDX_W : EDGE_W + 1;
  localparam logic [QUAL_RUN-1:0] ALL_ONES = '1;

  // reset synchronizer: assert async, release on clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // state
  logic             busy_q, en_q, done_q;
  logic [LEN_W-1:0] len_q, wcnt_q;
  scan_st_t         st_q;
  logic [IDX_W-1:0] lead_q;
  logic [HCNT_W:0]  status_q;

  // next-state
  logic             take, finish, scan_on, pre_open;
  logic             cur_en;
  logic [LEN_W-1:0] cur_len, cur_wcnt;
  scan_st_t         seed_st, scan_st, post_st;
  logic [IDX_W-1:0] seed_lead, scan_lead, post_lead, base;
  logic [MAX_HITS-1:0] scan_we, mem_we;
  logic [REC_W-1:0] scan_wdata [MAX_HITS];
  logic [REC_W-1:0] mem_wdata  [MAX_HITS];
  logic             tail_wr;
  logic [SLOT_W-1:0] tail_slot;
  logic [REC_W-1:0] tail_rec;
  logic             busy_d;
  logic [LEN_W-1:0] wcnt_d;
  logic [HCNT_W:0]  status_d;

  always_comb begin
    take     = in_valid && (in_first || busy_q);
    finish   = take && in_last;
    cur_en   = in_first ? chan_on     : en_q;
    cur_len  = in_first ? burst_words : len_q;
    cur_wcnt = in_first ? '0          : wcnt_q;
    scan_on  = take && (cur_wcnt < cur_len);
    pre_open = (burst_words != '0) &&
               (in_data[WORD_W-1 -: QUAL_RUN] == ALL_ONES);
    if (in_first) begin
      seed_st.open = pre_open;
      seed_st.hist = ALL_ONES;
      seed_st.hits = pre_open ? HCNT_W'(1) : '0;
      seed_lead    = '0;
    end else begin
      seed_st   = st_q;
      seed_lead = lead_q;
    end
    base = IDX_W'(cur_wcnt) * IDX_W'(WORD_W);
  end

  shed_word_scan #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_scan (
    .st_i    (seed_st),
    .lead_i  (seed_lead),
    .word_i  (in_data),
    .base_i  (base),
    .st_o    (scan_st),
    .lead_o  (scan_lead),
    .we_o    (scan_we),
    .wdata_o (scan_wdata)
  );

  always_comb begin
    post_st   = scan_on ? scan_st   : seed_st;
    post_lead = scan_on ? scan_lead : seed_lead;
    tail_wr   = finish && post_st.open;
    tail_slot = SLOT_W'(post_st.hits - HCNT_W'(1));
    tail_rec  = {clip_edge(32'(post_lead)), EDGE_SAT};
    for (int s = 0; s < MAX_HITS; s++) begin
      mem_we[s]    = cur_en && ((scan_on && scan_we[s]) ||
                                (tail_wr && tail_slot == SLOT_W'(s)));
      mem_wdata[s] = (tail_wr && tail_slot == SLOT_W'(s)) ? tail_rec
                                                         : scan_wdata[s];
    end
    busy_d   = take ? !in_last : busy_q;
    wcnt_d   = scan_on ? cur_wcnt + LEN_W'(1) : cur_wcnt;
    status_d = {cur_en, cur_en ? post_st.hits : HCNT_W'(0)};
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q   <= 1'b0;
      en_q     <= 1'b0;
      len_q    <= '0;
      wcnt_q   <= '0;
      st_q     <= '0;
      lead_q   <= '0;
      done_q   <= 1'b0;
      status_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= finish;
      if (take) begin
        en_q   <= cur_en;
        len_q  <= cur_len;
        wcnt_q <= wcnt_d;
        st_q   <= post_st;
        lead_q <= post_lead;
      end
      if (finish) status_q <= status_d;
    end
  end

  shed_result_mem u_mem (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .we_i      (mem_we),
    .wdata_i   (mem_wdata),
    .rd_slot_i (rd_slot),
    .rd_data_o (rd_rec_o)
  );

  assign done_o   = done_q;
  assign status_o = status_q;
endmodule

// File: rtl/shed_chk.sv
module shed_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_first,
  input logic       in_last,
  input logic       busy,
  input logic       done_o,
  input logic [3:0] status_o
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!done_o && status_o == 4'b0000);
    end
  end

  // R11
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(in_valid && in_last && (in_first || busy)));

  // R7
  hit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> status_o[2:0] <= 3'd4);

  // R8
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !status_o[3]) |-> status_o[2:0] == 3'd0);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(in_valid && in_first)) |=> !done_o);
endmodule

bind serial_hit_edge_det shed_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_first (in_first),
  .in_last  (in_last),
  .busy     (busy_q),
  .done_o   (done_o),
  .status_o (status_o)
);

// File: tb/serial_hit_edge_det_bench.sv
module serial_hit_edge_det_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_data = '0;
  logic       in_first = 1'b0;
  logic       in_last = 1'b0;
  logic       chan_on = 1'b0;
  logic [6:0] burst_words = '0;
  logic [1:0] rd_slot = '0;
  logic       done_o;
  logic [3:0] status_o;
  logic [15:0] rd_rec_o;

  always #(CLK_NS/2) clk = ~clk;

  serial_hit_edge_det u_serial_hit_edge_det (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .chan_on(chan_on),
    .burst_words(burst_words), .rd_slot(rd_slot), .done_o(done_o),
    .status_o(status_o), .rd_rec_o(rd_rec_o)
  );

  typedef struct {
    logic [3:0]  hw;
    logic [15:0] recs [4];
    string       tag;
  } exp_t;

  exp_t        exp_q [$];
  int          checks = 0;
  int          fails = 0;
  logic [15:0] shadow [4];
  logic [9:0]  bw [64];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic clr_words();
    for (int w = 0; w < 64; w++) bw[w] = '0;
  endtask

  task automatic put_run(input int start, input int len);
    for (int k = start; k < start + len; k++) bw[k/10][9 - (k%10)] = 1'b1;
  endtask

  function automatic logic bitat(input int k);
    return bw[k/10][9 - (k%10)];
  endfunction

  function automatic logic [7:0] sat(input int v);
    return (v > 255) ? 8'hFF : 8'(v);
  endfunction

  // reference from the requirements, then drive the words
  task automatic send_burst(input int n, input int cfg, input logic en, input string tag);
    exp_t e;
    logic [15:0] recs [4];
    int nb, hits, lead;
    bit open;
    for (int s = 0; s < 4; s++) recs[s] = shadow[s];
    nb = ((n < cfg) ? n : cfg) * 10;
    open = 0; hits = 0; lead = 0;
    if (cfg > 0 && bitat(0) && bitat(1) && bitat(2) && bitat(3)) begin
      open = 1; hits = 1; lead = 0;           // R5
    end
    for (int p = 4; p < nb; p++) begin
      if (!open) begin
        if (hits < 4 && !bitat(p-4) && bitat(p-3) && bitat(p-2) && bitat(p-1) && bitat(p)) begin
          open = 1; hits++; lead = p - 3;
        end
      end else if (bitat(p-4) && !bitat(p-3) && !bitat(p-2) && !bitat(p-1) && !bitat(p)) begin
        recs[hits-1] = {sat(lead), sat(p - 3 - lead)};
        open = 0;
      end
    end
    if (open) recs[hits-1] = {sat(lead), 8'hFF};   // R6
    if (en) begin
      e.hw = {1'b1, 3'(hits)};
      for (int s = 0; s < 4; s++) shadow[s] = recs[s];
    end else begin
      e.hw = 4'b0000;
    end
    for (int s = 0; s < 4; s++) e.recs[s] = shadow[s];
    e.tag = tag;
    exp_q.push_back(e);
    for (int w = 0; w < n; w++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = bw[w];
      in_first = (w == 0); in_last = (w == n - 1);
      chan_on = en; burst_words = 7'(cfg);
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: pop and compare on each completion
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check("R12 unexpected completion", 32'(done_o), 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " status"}, 32'(status_o), 32'(e.hw));
        for (int s = 0; s < 4; s++) begin
          rd_slot = 2'(s);
          #1;
          check({e.tag, " R11 slot ", $sformatf("%0d", s)}, 32'(rd_rec_o), 32'(e.recs[s]));
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) shadow[s] = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 done in reset", 32'(done_o), 32'd0);
    check("R1 status in reset", 32'(status_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 status after release", 32'(status_o), 32'd0);

    // R8 disabled, also R1 slots still zero
    clr_words(); put_run(12, 6);
    send_burst(4, 4, 1'b0, "R8 R1 disabled");
    // R2 R3 basic pulse
    clr_words(); put_run(12, 6);
    send_burst(4, 4, 1'b1, "R2 R3 basic");
    // R2 pulse straddling a word boundary
    clr_words(); put_run(8, 4); put_run(20, 9);
    send_burst(4, 4, 1'b1, "R2 straddle");
    // R4 short run and short gap
    clr_words(); put_run(3, 3); put_run(20, 5); put_run(30, 4); put_run(37, 5);
    send_burst(6, 6, 1'b1, "R4 short runs");
    // R8 disabled leaves slots untouched
    clr_words(); put_run(5, 5); put_run(15, 5);
    send_burst(3, 3, 1'b0, "R8 no write");
    // R5 pulse high at window start
    clr_words(); put_run(0, 8); put_run(20, 6);
    send_burst(3, 3, 1'b1, "R5 preloaded");
    // R5 three leading ones only
    clr_words(); put_run(0, 3); put_run(15, 4);
    send_burst(3, 3, 1'b1, "R5 three ones");
    // R6 open pulse, also three trailing zeros only
    clr_words(); put_run(20, 7);
    send_burst(3, 3, 1'b1, "R6 open");
    // R7 six pulses
    clr_words();
    for (int k = 0; k < 6; k++) put_run(5 + 10*k, 5);
    send_burst(7, 7, 1'b1, "R7 cap");
    // R7 dense alternating pattern
    clr_words();
    for (int k = 0; k < 5; k++) put_run(1 + 8*k, 4);
    send_burst(4, 4, 1'b1, "R7 dense");
    // R9 saturation of width and lead
    clr_words(); put_run(10, 270); put_run(300, 20);
    send_burst(40, 40, 1'b1, "R9 saturate");
    // R10 length truncation
    clr_words(); put_run(25, 10); put_run(45, 5);
    send_burst(6, 3, 1'b1, "R10 truncate");

    // R12 stray words outside a burst
    for (int w = 0; w < 5; w++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 10'h3C1; in_first = 1'b0; in_last = w[0];
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 stray words leave status", 32'(status_o), 32'h9);

    repeat (4) @(negedge clk);
    check("R11 every completion seen", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end
endmodule